// File: doc/BRIEF.md
# Two-Phase Stepped Pseudorandom Event Counter

This block counts events with a 9-bit maximal-length linear feedback shift register instead of a binary adder. The register walks through the 511 nonzero codes in a fixed pseudorandom order. Upstream logic produces one two-phase pulse pair per detected event: a first phase pulse followed, with no overlap, by a second phase pulse. The block samples both phase inputs on the system clock. While the first phase is high, a master register captures the successor of the visible code. On the first system-clock edge where the second phase is high after a first-phase pulse, that captured code is transferred to the visible state. A complete pair therefore moves the count by exactly one code, however long each pulse lasts.

A synchronous load plants a seed that acts as the new origin. A zero seed is replaced by the all-ones code, so the register can never lock up in the all-zero state. A one-cycle wrap flag marks each return of the visible state to the origin, which is the code set by the most recent reset or load. Converting the code back to binary is left to the reader of the array.

Top module: `lfsr_phase_counter`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `state` reads 9'h1FF and `wrap` reads 0.
- R2: One complete first-phase-then-second-phase pulse pair changes `state` from s to exactly {s[7:0], s[8] ^ s[4]}, which is the polynomial x^9 + x^5 + 1 with bit 8 as the most significant bit.
- R3: `state` changes only on the first clock edge where `phi2` is high after a `phi1` pulse. A `phi1` pulse on its own leaves `state` unchanged, and extra edges of a long `phi2` pulse leave it unchanged too.
- R4: A `phi2` pulse that has no preceding `phi1` pulse since the last transfer, reset or load has no effect on `state`.
- R5: Starting from any nonzero code, 511 pulse pairs visit 511 distinct nonzero codes and return to the starting code.
- R6: When `load_en` is high at a clock edge, `state` takes `seed` on that edge, or 9'h1FF if `seed` is zero. The load overrides a transfer in the same cycle and discards any pending `phi1` capture.
- R7: `wrap` is high for exactly one clock cycle, and that cycle is the one in which `state` returns to the code set by the most recent reset or load. Neither a load nor a reset pulses `wrap`.
- R8: Phase pulses as short as one system-clock cycle each, with no gap between them, still step the counter by one code per pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| phi1 | input | 1 | First phase of the event pulse pair; arms the master capture |
| phi2 | input | 1 | Second phase; transfers the captured code to the visible state |
| load_en | input | 1 | Synchronous seed load, highest priority |
| seed | input | 9 | Seed code; zero is replaced by 9'h1FF |
| state | output | 9 | Visible LFSR code |
| wrap | output | 1 | One-cycle pulse when the state returns to the origin |

## Verification
A seed load and a second-phase transfer can fall on the same clock edge, and this is where the block's two update paths compete. The bench arms the counter with a first-phase pulse, then raises the second phase and the load together on one edge. It then holds the second phase for further cycles after the load drops. It expects the seed on the visible state at once, no later step from the stale capture, and no wrap pulse. A second coincidence comes from the full-cycle walks: the transfer that closes the loop also raises the wrap flag on the same edge. The bench counts wrap cycles to confirm exactly one pulse per loop, even while the second phase is held for several cycles.

// File: rtl/lfsr_pc_pkg.sv
package lfsr_pc_pkg;

    localparam int unsigned     DEF_W    = 9;
    localparam logic [DEF_W-1:0] DEF_TAPS = 9'h110;

    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_ARMED = 1'b1
    } phase_st_e;

endpackage

// File: rtl/lfsr_feedback.sv
module lfsr_feedback #(
    parameter int unsigned W    = lfsr_pc_pkg::DEF_W,
    parameter logic [W-1:0] TAPS = lfsr_pc_pkg::DEF_TAPS
) (
    input  logic [W-1:0] cur,
    output logic [W-1:0] nxt
);

    logic [W-1:0] shifted;

    assign shifted[0] = ^(cur & TAPS);

    for (genvar i = 1; i < W; i++) begin : g_shift
        assign shifted[i] = cur[i-1];
    end

    // Lockup guard: an all-zero input would never leave zero.
    assign nxt = (cur == '0) ? '1 : shifted;

endmodule

// File: rtl/phase_sequencer.sv
module phase_sequencer (
    input  logic clk,
    input  logic rst_n,
    input  logic phi1,
    input  logic phi2,
    input  logic clear,
    output logic capture,
    output logic transfer
);
    import lfsr_pc_pkg::*;

    phase_st_e st_d, st_q;

    always_comb begin
        capture  = phi1 && !clear;
        transfer = (st_q == PH_ARMED) && phi2 && !phi1 && !clear;
        st_d     = st_q;
        if (clear) begin
            st_d = PH_IDLE;
        end else if (phi1) begin
            st_d = PH_ARMED;
        end else if (transfer) begin
            st_d = PH_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= PH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // R4: a second phase with no arming first never moves the sequencer out of idle
    a_r4_idle_phi2_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PH_IDLE && !phi1) |=> (st_q == PH_IDLE));

endmodule

// File: rtl/lfsr_phase_counter.sv
module lfsr_phase_counter #(
    parameter int unsigned  W    = lfsr_pc_pkg::DEF_W,
    parameter logic [W-1:0] TAPS = lfsr_pc_pkg::DEF_TAPS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         phi1,
    input  logic         phi2,
    input  logic         load_en,
    input  logic [W-1:0] seed,
    output logic [W-1:0] state,
    output logic         wrap
);

    localparam logic [W-1:0] FILL = '1;

    typedef struct packed {
        logic [W-1:0] master;
        logic [W-1:0] shown;
        logic [W-1:0] origin;
        logic         wrap;
    } ctr_t;

    ctr_t         ctr_d, ctr_q;
    logic         capture, transfer;
    logic [W-1:0] succ;
    logic [W-1:0] seed_fix;

    phase_sequencer u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .phi1     (phi1),
        .phi2     (phi2),
        .clear    (load_en),
        .capture  (capture),
        .transfer (transfer)
    );

    lfsr_feedback #(.W(W), .TAPS(TAPS)) u_fb (
        .cur (ctr_q.shown),
        .nxt (succ)
    );

    always_comb begin
        seed_fix   = (seed == '0) ? FILL : seed;
        ctr_d      = ctr_q;
        ctr_d.wrap = 1'b0;
        if (load_en) begin
            ctr_d.master = seed_fix;
            ctr_d.shown  = seed_fix;
            ctr_d.origin = seed_fix;
        end else begin
            if (capture) begin
                ctr_d.master = succ;
            end
            if (transfer) begin
                ctr_d.shown = ctr_q.master;
                ctr_d.wrap  = (ctr_q.master == ctr_q.origin);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctr_q <= '{master: FILL, shown: FILL, origin: FILL, wrap: 1'b0};
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign state = ctr_q.shown;
    assign wrap  = ctr_q.wrap;

    // R2: every change of the visible code that is not a load is one feedback step
    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(state) && !$past(load_en)) |->
        (state == {$past(state[W-2:0]), ^($past(state) & TAPS)}));

    // R3: with no second phase and no load, the visible code holds
    a_r3_hold_without_phi2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !phi2) |=> $stable(state));

    // R6: a load lands on the next edge, with zero replaced by all ones
    a_r6_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (state == (($past(seed) == '0) ? FILL : $past(seed))));

    // R6: the all-zero code is never visible
    a_r6_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
        state != '0);

    // R7: wrap only accompanies a fresh step, never a held code
    a_r7_wrap_on_step: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |-> (!$stable(state) && !$past(load_en)));

endmodule

// File: tb/lfsr_phase_counter_test.sv
module lfsr_phase_counter_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       phi1 = 1'b0;
    logic       phi2 = 1'b0;
    logic       load_en = 1'b0;
    logic [8:0] seed = '0;
    logic [8:0] state;
    logic       wrap;

    int total = 0;
    int bad = 0;
    int wrap_cnt = 0;
    bit done = 0;
    logic [8:0] exp_s;

    always #2 clk = ~clk;

    lfsr_phase_counter uut (
        .clk(clk), .rst_n(rst_n), .phi1(phi1), .phi2(phi2),
        .load_en(load_en), .seed(seed), .state(state), .wrap(wrap)
    );

    // Counts system-clock cycles in which wrap is high
    always @(posedge clk) begin
        #1;
        if (rst_n && wrap) wrap_cnt++;
    end

    // seed[27:19] steps[18:8] phi1 cycles[7:4] phi2 cycles[3:0]
    localparam logic [27:0] VEC [5] = '{
        {9'h001, 11'd5,   4'd1, 4'd1},
        {9'h0A5, 11'd20,  4'd3, 4'd2},
        {9'h100, 11'd37,  4'd1, 4'd4},
        {9'h000, 11'd3,   4'd2, 4'd1},
        {9'h1FF, 11'd100, 4'd4, 4'd3}
    };

    function automatic logic [8:0] model_next(logic [8:0] s);
        return {s[7:0], s[8] ^ s[4]};
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(string req, logic [8:0] act, logic [8:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pair(int n1, int n2, int gap);
        phi1 = 1'b1;
        repeat (n1) tick();
        phi1 = 1'b0;
        repeat (gap) tick();
        phi2 = 1'b1;
        repeat (n2) tick();
        phi2 = 1'b0;
        tick();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) tick();
        check("R1 state in reset", state, 9'h1FF);
        check("R1 wrap in reset", {8'd0, wrap}, 9'd0);
        rst_n = 1'b1;
        tick();
    endtask

    initial begin
        bit seen [512];
        int w0;
        logic [8:0] start;
        tick();
        // R1
        do_reset();
        check("R1 state after reset", state, 9'h1FF);
        check("R1 wrap after reset", {8'd0, wrap}, 9'd0);

        // R4: second phase alone is ignored
        phi2 = 1'b1; repeat (3) tick(); phi2 = 1'b0; tick();
        check("R4 lone phi2", state, 9'h1FF);

        // R3: first phase alone does not move the visible code
        phi1 = 1'b1; repeat (2) tick(); phi1 = 1'b0; tick();
        check("R3 phi1 only", state, 9'h1FF);
        phi2 = 1'b1; tick();
        check("R3 first phi2 edge", state, model_next(9'h1FF));
        repeat (3) tick();
        phi2 = 1'b0; tick();
        check("R3 long phi2", state, model_next(9'h1FF));
        phi2 = 1'b1; repeat (2) tick(); phi2 = 1'b0; tick();
        check("R4 phi2 after transfer", state, model_next(9'h1FF));

        // Vector table: R2 stepping, R6 seed load including zero seed
        for (int v = 0; v < 5; v++) begin
            seed = VEC[v][27:19];
            load_en = 1'b1; tick(); load_en = 1'b0;
            exp_s = (VEC[v][27:19] == 9'd0) ? 9'h1FF : VEC[v][27:19];
            check("R6 table load", state, exp_s);
            for (int k = 0; k < int'(VEC[v][18:8]); k++) begin
                pair(int'(VEC[v][7:4]), int'(VEC[v][3:0]), 1);
                exp_s = model_next(exp_s);
            end
            check("R2 table steps", state, exp_s);
        end

        // R5 and R7: full loop from the reset origin, long second phase
        do_reset();
        w0 = wrap_cnt;
        exp_s = 9'h1FF;
        for (int i = 0; i < 512; i++) seen[i] = 1'b0;
        seen[9'h1FF] = 1'b1;
        begin
            int dup = 0;
            for (int k = 0; k < 510; k++) begin
                pair(1, 3, 0);
                exp_s = model_next(exp_s);
                if (state == 9'd0 || seen[state]) dup++;
                seen[state] = 1'b1;
                if (state !== exp_s) dup++;
            end
            check("R5 distinct codes", dup[8:0], 9'd0);
        end
        check("R7 no early wrap", wrap_cnt[8:0] - w0[8:0], 9'd0);
        pair(1, 3, 0);
        check("R5 loop closes", state, 9'h1FF);
        check("R7 one wrap cycle", wrap_cnt[8:0] - w0[8:0], 9'd1);

        // R6 and R7: load collides with an armed transfer
        pair(1, 1, 0);
        w0 = wrap_cnt;
        phi1 = 1'b1; tick(); phi1 = 1'b0; tick();
        phi2 = 1'b1; load_en = 1'b1; seed = 9'h0C3; tick();
        load_en = 1'b0;
        check("R6 load beats transfer", state, 9'h0C3);
        repeat (2) tick();
        phi2 = 1'b0; tick();
        check("R6 capture discarded", state, 9'h0C3);
        check("R7 no wrap on load", wrap_cnt[8:0] - w0[8:0], 9'd0);

        // R8 and R7: full loop from a loaded origin with one-cycle phases
        start = 9'h0C3;
        exp_s = start;
        for (int k = 0; k < 255; k++) begin
            pair(1, 1, 0);
            exp_s = model_next(exp_s);
        end
        check("R8 short pulses", state, exp_s);
        for (int k = 0; k < 256; k++) pair(1, 1, 0);
        check("R8 loaded loop closes", state, start);
        check("R7 wrap at loaded origin", wrap_cnt[8:0] - w0[8:0], 9'd1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule